// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Pin Ownership

The block is an 8-pin general-purpose port. It sits behind a small register bus. Software sets a direction for each pin and a value to drive, and it reads back the synchronised level of every pad.

Three peripheral enables can take pins away from the port:
- a serial peripheral interface enable claims the upper four pins;
- an asynchronous transmitter enable claims pin 1 as a driven output;
- an asynchronous receiver enable claims pin 0 as an input.

While a pin is claimed, its direction bit is ignored. When the enable drops, the direction bit controls the pin again. Only six of the eight direction bits exist. Pins 2 and 3 can only ever be inputs.

Pad levels pass through a two-flop synchroniser. The synchronised levels feed the input register, the peripheral receive data and the serial receive data. For each pin the block produces an output enable and an output value for the pad.

Top module: `pinmux_port`

## Requirements
- R1: After a synchronous active-low reset, the data-output register (address 0) and the direction register (address 1) read 0, and every pad_oe bit is 0.
- R2: The direction register at address 1 is read/write. Bits 7:4 and 1:0 hold the written value. Bits 3:2 always read 0, ignore writes, and leave pins 3:2 undriven. A direction bit of 1 makes the pin an output and 0 makes it an input.
- R3: The data-output register at address 0 is read/write, all 8 bits. It supplies pad_out for every pin that the port owns.
- R4: Address 2 returns the pad levels delayed by two clock edges: a pad change is visible in bus_rdata after the second rising edge. Writes to address 2 change no register.
- R5: While spi_en is 1, pad_oe[7:4] equals spi_oe and pad_out[7:4] equals spi_do, whatever the direction bits hold. spi_di always carries the synchronised levels of pins 7:4.
- R6: While ser_tx_en is 1, pad_oe[1] is 1 and pad_out[1] equals ser_tx_d, regardless of direction bit 1.
- R7: While ser_rx_en is 1, pad_oe[0] is 0 regardless of direction bit 0. ser_rx_d always carries the synchronised level of pin 0.
- R8: When spi_en, ser_tx_en and ser_rx_en are all 0, pad_oe again equals the direction register and pad_out equals the data-output register.
- R9: Address 3 reads 0, and writes to it change no register.
- R10: For each port-owned pin, pad_oe follows the direction register in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register select: 0 data-out, 1 direction, 2 pin levels, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| spi_en | input | 1 | Serial peripheral interface takes pins 7:4 |
| spi_oe | input | 4 | Output enables for pins 7:4 from the SPI |
| spi_do | input | 4 | Output data for pins 7:4 from the SPI |
| spi_di | output | 4 | Synchronised levels of pins 7:4 |
| ser_tx_en | input | 1 | Transmitter takes pin 1 |
| ser_tx_d | input | 1 | Transmit data for pin 1 |
| ser_rx_en | input | 1 | Receiver takes pin 0 |
| ser_rx_d | output | 1 | Synchronised level of pin 0 |

## Verification
Some faults live in stored state: a lost or corrupted direction or data bit, or a stuck unimplemented bit. These show up on pad_oe, pad_out and the register readback in the first cycle after the write that should have set them. A synchroniser with the wrong number of stages makes the pin register and the receive outputs change one edge early or late. The checks step through that two-edge window. Ownership faults are purely combinational: they appear on pad_oe or pad_out in the same cycle as the enable change, and also in the cycle after it is released.

// File: rtl/pinmux_pkg.sv
// Shared definitions for the GPIO port with peripheral pin ownership.
// Assumes a 2-bit register select on the bus.
package pinmux_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DOUT = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PINS = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pinmux_sync.sv
// Multi-stage synchroniser for the pad inputs.
// Assumes pad_in is asynchronous to clk. Output lags the pad by STAGES edges.
module pinmux_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] sync_out
);
    localparam int CNT_W = $clog2(STAGES + 1);

    logic [N_PINS-1:0] stage_q [STAGES];

    // Shift the pad levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= pad_in;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    // Count edges since reset so the delay check starts once the chain is full.
    logic [CNT_W-1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           warm_q <= '0;
        else if (warm_q != CNT_W'(STAGES))    warm_q <= warm_q + 1'b1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            a_r4_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == CNT_W'(STAGES)) |-> (sync_out == $past(pad_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/pinmux_regs.sv
// Register bank: data-output and direction registers, plus read decode.
// Assumes a single-cycle write strobe and combinational read. Direction bits
// not set in DIR_IMPL are not stored and read 0.
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int              N_PINS   = 8,
    parameter logic [N_PINS-1:0] DIR_IMPL = 8'hF3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    input  logic [N_PINS-1:0] pin_state,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] dout_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    logic wr_dir, wr_dout;
    assign wr_dir  = bus_wr && (sel == SEL_DIR);
    assign wr_dout = bus_wr && (sel == SEL_DOUT);

    // Data-output register: all bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= '0;
        else if (wr_dout) dout_q <= bus_wdata;
    end

    // Direction register: only the implemented bits get a flop.
    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_dir
            if (DIR_IMPL[i]) begin : g_impl
                always_ff @(posedge clk) begin
                    if (!rst_n)      dir_q[i] <= 1'b0;
                    else if (wr_dir) dir_q[i] <= bus_wdata[i];
                end
            end else begin : g_tie
                assign dir_q[i] = 1'b0;
            end
        end
    endgenerate

    // Read multiplexer.
    always_comb begin
        unique case (sel)
            SEL_DOUT: bus_rdata = dout_q;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_PINS: bus_rdata = pin_state;
            default:  bus_rdata = '0;
        endcase
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && dout_q == '0));
    a_r2_dir_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == ($past(bus_wdata) & DIR_IMPL)));
    a_r9_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_dir || wr_dout) |=> ($stable(dir_q) && $stable(dout_q)));
endmodule

// File: rtl/pinmux_owner.sv
// Per-pin ownership multiplexer. It picks pad enable and value from the SPI,
// the transmitter, the receiver or the GPIO registers. Purely combinational.
module pinmux_owner #(
    parameter int N_PINS   = 8,
    parameter int SPI_BASE = 4,
    parameter int SPI_CNT  = 4,
    parameter int TX_PIN   = 1,
    parameter int RX_PIN   = 0
) (
    input  logic [N_PINS-1:0]  dir_q,
    input  logic [N_PINS-1:0]  dout_q,
    input  logic               spi_en,
    input  logic [SPI_CNT-1:0] spi_oe,
    input  logic [SPI_CNT-1:0] spi_do,
    input  logic               ser_tx_en,
    input  logic               ser_tx_d,
    input  logic               ser_rx_en,
    output logic [N_PINS-1:0]  pad_oe,
    output logic [N_PINS-1:0]  pad_out
);
    // Each pin gets the mux variant that matches its owner group.
    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            if (i >= SPI_BASE && i < SPI_BASE + SPI_CNT) begin : g_spi
                assign pad_oe[i]  = spi_en ? spi_oe[i-SPI_BASE] : dir_q[i];
                assign pad_out[i] = spi_en ? spi_do[i-SPI_BASE] : dout_q[i];
            end else if (i == TX_PIN) begin : g_tx
                assign pad_oe[i]  = ser_tx_en ? 1'b1 : dir_q[i];
                assign pad_out[i] = ser_tx_en ? ser_tx_d : dout_q[i];
            end else if (i == RX_PIN) begin : g_rx
                assign pad_oe[i]  = ser_rx_en ? 1'b0 : dir_q[i];
                assign pad_out[i] = dout_q[i];
            end else begin : g_gpio
                assign pad_oe[i]  = dir_q[i];
                assign pad_out[i] = dout_q[i];
            end
        end
    endgenerate
endmodule

// File: rtl/pinmux_port.sv
// Top level of the 8-pin GPIO port with peripheral pin ownership.
// It ties together the synchroniser, the register bank and the ownership mux.
// Assumes a synchronous active-low reset and a single clock domain for the bus.
module pinmux_port
    import pinmux_pkg::*;
#(
    parameter int                N_PINS      = 8,
    parameter int                SPI_BASE    = 4,
    parameter int                SPI_CNT     = 4,
    parameter int                TX_PIN      = 1,
    parameter int                RX_PIN      = 0,
    parameter int                SYNC_STAGES = 2,
    parameter logic [N_PINS-1:0] DIR_IMPL    = 8'hF3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_PINS-1:0]  bus_wdata,
    output logic [N_PINS-1:0]  bus_rdata,
    input  logic [N_PINS-1:0]  pad_in,
    output logic [N_PINS-1:0]  pad_oe,
    output logic [N_PINS-1:0]  pad_out,
    input  logic               spi_en,
    input  logic [SPI_CNT-1:0] spi_oe,
    input  logic [SPI_CNT-1:0] spi_do,
    output logic [SPI_CNT-1:0] spi_di,
    input  logic               ser_tx_en,
    input  logic               ser_tx_d,
    input  logic               ser_rx_en,
    output logic               ser_rx_d
);
    logic [N_PINS-1:0] pins_s;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] dout_q;

    pinmux_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .sync_out (pins_s)
    );

    pinmux_regs #(.N_PINS(N_PINS), .DIR_IMPL(DIR_IMPL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_state (pins_s),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .dout_q    (dout_q)
    );

    pinmux_owner #(
        .N_PINS(N_PINS), .SPI_BASE(SPI_BASE), .SPI_CNT(SPI_CNT),
        .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)
    ) u_owner (
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .spi_en    (spi_en),
        .spi_oe    (spi_oe),
        .spi_do    (spi_do),
        .ser_tx_en (ser_tx_en),
        .ser_tx_d  (ser_tx_d),
        .ser_rx_en (ser_rx_en),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    // Peripheral receive paths take the synchronised pad levels.
    assign spi_di   = pins_s[SPI_BASE +: SPI_CNT];
    assign ser_rx_d = pins_s[RX_PIN];

    a_r2_unimpl_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~DIR_IMPL) == '0));
    a_r5_spi_owns: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (pad_oe[SPI_BASE +: SPI_CNT] == spi_oe &&
                    pad_out[SPI_BASE +: SPI_CNT] == spi_do));
    a_r6_tx_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ser_tx_en |-> (pad_oe[TX_PIN] && pad_out[TX_PIN] == ser_tx_d));
    a_r7_rx_input: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rx_en |-> !pad_oe[RX_PIN]);
    a_r10_dir_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DIR && !spi_en && !ser_tx_en && !ser_rx_en) |=>
        (spi_en || ser_tx_en || ser_rx_en || pad_oe == ($past(bus_wdata) & DIR_IMPL)));
endmodule

// File: tb/pinmux_port_test.sv
`timescale 1ns/1ps
module pinmux_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out;
    logic       spi_en = 1'b0;
    logic [3:0] spi_oe = '0, spi_do = '0, spi_di;
    logic       ser_tx_en = 1'b0, ser_tx_d = 1'b0, ser_rx_en = 1'b0, ser_rx_d;

    always #10 clk = ~clk;

    pinmux_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .spi_en(spi_en), .spi_oe(spi_oe),
        .spi_do(spi_do), .spi_di(spi_di), .ser_tx_en(ser_tx_en),
        .ser_tx_d(ser_tx_d), .ser_rx_en(ser_rx_en), .ser_rx_d(ser_rx_d)
    );

    // Item selectors: 0 rdata, 1 pad_oe, 2 pad_out, 3 spi_di, 4 ser_rx_d
    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    item_t it;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [7:0] act;

    // Monitor: compares every queued expectation away from the active edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.sel)
                0:       act = bus_rdata;
                1:       act = pad_oe;
                2:       act = pad_out;
                3:       act = {4'b0, spi_di};
                default: act = {7'b0, ser_rx_d};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int sel, logic [7:0] exp, string tag);
        item_t n;
        n.sel = sel; n.exp = exp; n.tag = tag;
        q.push_back(n);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        bus_addr = a;
        push(0, exp, tag);
        tick();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        pad_in = 8'hA5;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: registers and enables come out of reset at 0
        bus_addr = 2'd0; push(0, 8'h00, "R1 dout reset"); push(1, 8'h00, "R1 oe reset");
        tick();
        rd(2'd1, 8'h00, "R1 dir reset");
        // R4: pad levels after two edges since release
        rd(2'd2, 8'hA5, "R4 pins after reset");
        pad_in = 8'h3C;
        rd(2'd2, 8'hA5, "R4 edge0");
        rd(2'd2, 8'hA5, "R4 edge1");
        rd(2'd2, 8'h3C, "R4 edge2");
        // R4: write to pin register ignored
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'h3C, "R4 pins after write");
        rd(2'd0, 8'h00, "R4 dout untouched");
        rd(2'd1, 8'h00, "R4 dir untouched");
        // R2: implemented bits only
        wr(2'd1, 8'hFF);
        bus_addr = 2'd1; push(1, 8'hF3, "R10 oe follows dir");
        rd(2'd1, 8'hF3, "R2 dir all ones");
        wr(2'd1, 8'h0C);
        bus_addr = 2'd1; push(1, 8'h00, "R2 oe bits3:2");
        rd(2'd1, 8'h00, "R2 dir bits3:2 ignored");
        wr(2'd1, 8'hFF);
        // R3: data-out register drives GPIO pins
        wr(2'd0, 8'h5A);
        bus_addr = 2'd0; push(2, 8'h5A, "R3 pad_out"); push(1, 8'hF3, "R10 oe");
        rd(2'd0, 8'h5A, "R3 dout read");
        // R9: unused address
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h00, "R9 unused reads 0");
        rd(2'd0, 8'h5A, "R9 dout kept");
        rd(2'd1, 8'hF3, "R9 dir kept");
        // R5: SPI ownership of pins 7:4
        spi_en = 1'b1; spi_oe = 4'b0101; spi_do = 4'b1100;
        push(1, 8'h53, "R5 spi oe"); push(2, 8'hCA, "R5 spi out"); push(3, 8'h03, "R5 spi_di");
        tick();
        spi_en = 1'b0;
        push(1, 8'hF3, "R8 spi released oe"); push(2, 8'h5A, "R8 spi released out");
        tick();
        // R6: transmitter owns pin 1
        wr(2'd1, 8'h00);
        ser_tx_en = 1'b1; ser_tx_d = 1'b0;
        push(1, 8'h02, "R6 tx oe"); push(2, 8'h58, "R6 tx low");
        tick();
        ser_tx_d = 1'b1;
        push(2, 8'h5A, "R6 tx high");
        tick();
        // R5: all three owners together, direction 0
        spi_en = 1'b1; ser_rx_en = 1'b1;
        push(1, 8'h52, "R5 combined oe");
        tick();
        spi_en = 1'b0; ser_tx_en = 1'b0; ser_rx_en = 1'b0;
        // R7: receiver owns pin 0
        wr(2'd1, 8'hFF);
        ser_rx_en = 1'b1;
        push(1, 8'hF2, "R7 rx oe"); push(4, 8'h00, "R7 rxd low");
        tick();
        pad_in = 8'h3D;
        tick();
        tick();
        push(4, 8'h01, "R7 rxd high");
        tick();
        ser_rx_en = 1'b0;
        push(1, 8'hF3, "R8 rx released oe"); push(2, 8'h5A, "R8 out");
        tick();
        tick();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule